// File: doc/BRIEF.md
# Bit-Serial Shift and Rotate Unit

This block moves a byte or word operand left or right by one position per clock, over a number of positions given either as the constant one or by a count input. Seven operations are supported. Two rotate through the carry bit, so the carry acts as one extra bit of the ring. Two rotate the operand on itself. Three are shifts: left, arithmetic right and logical right. Every operation returns a carry-out that holds the last bit moved out of the operand.

A caller pulses `start` together with the operand, width select, operation code, count source, count and carry-in. The unit then stays busy, making one move per clock. When it has finished, it pulses `done` for a single clock, with `result` and `carry_out` already valid. These two outputs hold their values until the next accepted start.

Top module: `bitstep_shifter`

## Requirements
- R1: While reset is asserted and after its release, `result` and `carry_out` are 0 and `busy` and `done` are low.
- R2: When `start` is high and `busy` is low, the request is accepted. The position count is `cnt_reg` when `use_cnt_reg` is 1, and 1 otherwise. For a count N, `busy` stays high for N+1 clocks after the accepting edge, and `done` is high for exactly the one clock after that.
- R3: A `start` while `busy` is high is ignored: the running operation finishes with the result and timing of the original request.
- R4: Operation code 0 (rotate left through carry): each move puts the operand MSB into carry and the previous carry into the LSB.
- R5: Operation code 1 (rotate right through carry): each move puts the LSB into carry and the previous carry into the MSB.
- R6: Operation code 2 (rotate left) moves the MSB into the LSB and copies it into carry. Operation code 3 (rotate right) moves the LSB into the MSB and copies it into carry.
- R7: Operation code 4 (shift left) inserts 0 at the LSB and moves the MSB into carry.
- R8: Operation code 5 (arithmetic shift right) keeps the MSB, shifts it down, and moves the LSB into carry.
- R9: Operation code 6 (logical shift right) inserts 0 at the MSB and moves the LSB into carry.
- R10: Operation code 7 leaves the operand and carry unchanged while still taking the normal count of clocks.
- R11: With `wide` = 0 the operation acts on bits 7:0 only, using bit 7 as the MSB, and result bits 15:8 equal operand bits 15:8. With `wide` = 1 all 16 bits take part.
- R12: A count of 0 returns the operand and carry-in unchanged, and `done` pulses on the second clock after the accepting edge.
- R13: After a move of several positions, `carry_out` holds the bit most recently moved out. Bits moved out earlier are lost. A shift count greater than the width leaves 0 in carry for the left and logical right shifts, and the sign bit for the arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken when idle |
| operand | input | 16 | Value to shift or rotate |
| wide | input | 1 | 1 = word, 0 = low byte |
| op | input | 3 | Operation code (see R4 to R10) |
| use_cnt_reg | input | 1 | 1 = count from `cnt_reg`, 0 = count of one |
| cnt_reg | input | 8 | Position count |
| carry_in | input | 1 | Initial carry |
| busy | output | 1 | Operation in progress |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | Last bit moved out |
| done | output | 1 | One-clock completion pulse |

## Verification
The sweep covers every operation code, both widths, both carry-in values and counts from 0 up past the word width plus one. These counts include the lengths where a through-carry ring or a plain rotate wraps back to its start. A design that sized the through-carry ring at the operand width would show wrong values at count 9 (byte) or 17 (word). A design that kept the first bit moved out instead of the last would show a wrong carry on every multi-position count. A design that let byte moves leak into bit 8 or above would corrupt the upper byte. The arithmetic shift is checked past the width, where it must fill with the sign bit. The bench also checks that a count of zero completes one clock later with nothing changed, and that a start raised in the middle of a run neither restarts the run nor changes its result.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [2:0] {
    OP_RCL = 3'd0,
    OP_RCR = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_SHL = 3'd4,
    OP_SAR = 3'd5,
    OP_SHR = 3'd6,
    OP_NOP = 3'd7
  } bsh_op_e;
endpackage

// File: rtl/bsh_step.sv
// One-position move of the operand and carry (combinational).
module bsh_step #(
  parameter int W = 16
) (
  input  bsh_pkg::bsh_op_e op,
  input  logic             wide,
  input  logic [W-1:0]     d_in,
  input  logic             c_in,
  output logic [W-1:0]     d_out,
  output logic             c_out
);
  import bsh_pkg::*;
  localparam int B = W / 2;

  // Returns {carry, data} after a single move; top is the active MSB index.
  function automatic logic [W:0] move1(input bsh_op_e o, input logic [W-1:0] v,
                                       input logic ci, input int top);
    logic [W-1:0] nv;
    logic         co;
    nv = v;
    co = ci;
    case (o)
      OP_RCL: begin nv = (v << 1) | {{(W-1){1'b0}}, ci};   co = v[top]; end
      OP_RCR: begin nv = v >> 1; nv[top] = ci;             co = v[0];   end
      OP_ROL: begin nv = (v << 1) | {{(W-1){1'b0}}, v[top]}; co = v[top]; end
      OP_ROR: begin nv = v >> 1; nv[top] = v[0];           co = v[0];   end
      OP_SHL: begin nv = v << 1;                           co = v[top]; end
      OP_SAR: begin nv = v >> 1; nv[top] = v[top];         co = v[0];   end
      OP_SHR: begin nv = v >> 1; nv[top] = 1'b0;           co = v[0];   end
      default: begin nv = v;                               co = ci;     end
    endcase
    return {co, nv};
  endfunction

  logic [W-1:0] act_mask;
  logic [W:0]   mv;

  assign act_mask = wide ? {W{1'b1}} : {{(W-B){1'b0}}, {B{1'b1}}};
  assign mv       = move1(op, d_in, c_in, wide ? W-1 : B-1);
  assign d_out    = (mv[W-1:0] & act_mask) | (d_in & ~act_mask);
  assign c_out    = mv[W];
endmodule

// File: rtl/bsh_seq.sv
// Position counter and busy/done sequencing.
module bsh_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_cnt,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             busy,
  output logic             accept,
  output logic             step_fire,
  output logic             finish,
  output logic             done
);
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             done_q;

  assign accept    = start & ~busy_q;
  assign step_fire = busy_q & (rem_q != '0);
  assign finish    = busy_q & (rem_q == '0);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        rem_q  <= use_cnt ? cnt_in : CNT_W'(1);
      end else if (step_fire) begin
        rem_q  <= rem_q - CNT_W'(1);
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitstep_shifter.sv
module bitstep_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] operand,
  input  logic              wide,
  input  logic [2:0]        op,
  input  logic              use_cnt_reg,
  input  logic [CNT_W-1:0]  cnt_reg,
  input  logic              carry_in,
  output logic              busy,
  output logic [WORD_W-1:0] result,
  output logic              carry_out,
  output logic              done
);
  import bsh_pkg::*;

  logic              accept, step_fire, finish;
  logic [WORD_W-1:0] data_q, data_nx;
  logic              carry_q, carry_nx;
  bsh_op_e           op_q;
  logic              wide_q;

  bsh_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .use_cnt(use_cnt_reg),
    .cnt_in(cnt_reg), .busy(busy), .accept(accept), .step_fire(step_fire),
    .finish(finish), .done(done)
  );

  bsh_step #(.W(WORD_W)) u_step (
    .op(op_q), .wide(wide_q), .d_in(data_q), .c_in(carry_q),
    .d_out(data_nx), .c_out(carry_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      op_q    <= OP_RCL;
      wide_q  <= 1'b0;
    end else if (accept) begin
      data_q  <= operand;
      carry_q <= carry_in;
      op_q    <= bsh_op_e'(op);
      wide_q  <= wide;
    end else if (step_fire) begin
      data_q  <= data_nx;
      carry_q <= carry_nx;
    end
  end

  assign result    = data_q;
  assign carry_out = carry_q;
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             use_cnt_reg,
  input logic [CNT_W-1:0] cnt_reg,
  input logic             busy,
  input logic             done,
  input logic [W-1:0]     result,
  input logic             carry_out,
  input logic             step_fire,
  input logic [2:0]       op_q,
  input logic             wide_q
);
  localparam int B = W / 2;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_fire) |=> ($stable(result) && $stable(carry_out))); // R3
  AST_SHL_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && op_q == 3'd4 && wide_q) |=>
      (result == ($past(result) << 1) && carry_out == $past(result[W-1]))); // R7
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !wide_q) |=> (result[W-1:B] == $past(result[W-1:B]))); // R11
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && use_cnt_reg && cnt_reg == '0) |=>
      (busy ##1 (done && $stable(result) && $stable(carry_out)))); // R12
endmodule

bind bitstep_shifter bsh_checker #(.W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .use_cnt_reg(use_cnt_reg),
  .cnt_reg(cnt_reg), .busy(busy), .done(done), .result(result),
  .carry_out(carry_out), .step_fire(step_fire), .op_q(op_q), .wide_q(wide_q)
);

// File: tb/bitstep_shifter_test.sv
module bitstep_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] operand = '0;
  logic        wide = 1'b0;
  logic [2:0]  op = '0;
  logic        use_cnt_reg = 1'b0;
  logic [7:0]  cnt_reg = '0;
  logic        carry_in = 1'b0;
  logic        busy, carry_out, done;
  logic [15:0] result;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstep_shifter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .wide(wide),
    .op(op), .use_cnt_reg(use_cnt_reg), .cnt_reg(cnt_reg), .carry_in(carry_in),
    .busy(busy), .result(result), .carry_out(carry_out), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference result computed arithmetically over the whole count: {carry, data}.
  function automatic logic [16:0] model(input logic [2:0] o, input bit wd,
                                        input logic [15:0] d, input bit c, input int n);
    int     w;
    int     m;
    longint v, mk, ring, rmk, nv;
    bit     co, sg;
    w   = wd ? 16 : 8;
    v   = wd ? longint'(d) : longint'(d[7:0]);
    mk  = (longint'(1) << w) - 1;
    rmk = (longint'(1) << (w + 1)) - 1;
    nv  = v;
    co  = c;
    sg  = v[w-1];
    if (n != 0) begin
      case (o)
        3'd0: begin
          m = n % (w + 1); ring = (longint'(c) << w) | v;
          ring = ((ring << m) | (ring >> (w + 1 - m))) & rmk;
          co = ring[w]; nv = ring & mk;
        end
        3'd1: begin
          m = n % (w + 1); ring = (longint'(c) << w) | v;
          ring = ((ring >> m) | (ring << (w + 1 - m))) & rmk;
          co = ring[w]; nv = ring & mk;
        end
        3'd2: begin m = n % w; nv = ((v << m) | (v >> (w - m))) & mk; co = nv[0]; end
        3'd3: begin m = n % w; nv = ((v >> m) | (v << (w - m))) & mk; co = nv[w-1]; end
        3'd4: begin nv = (v << n) & mk; co = (n <= w) ? v[w-n] : 1'b0; end
        3'd5: begin
          if (n >= w) nv = sg ? mk : 0;
          else nv = (v >> n) | (sg ? (mk & ~(mk >> n)) : 0);
          co = (n <= w) ? v[n-1] : sg;
        end
        3'd6: begin nv = v >> n; co = (n <= w) ? v[n-1] : 1'b0; end
        default: begin nv = v; co = c; end
      endcase
    end
    return wd ? {co, nv[15:0]} : {co, d[15:8], nv[7:0]};
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_one(input logic [2:0] o, input bit wd, input logic [15:0] d,
                         input bit c, input bit usec, input int cnt, input bit poke);
    int n;
    int took;
    logic [16:0] exp;
    string tg;
    n = usec ? cnt : 1;
    exp = model(o, wd, d, c, n);
    @(negedge clk);
    start = 1'b1; operand = d; wide = wd; op = o;
    use_cnt_reg = usec; cnt_reg = 8'(cnt); carry_in = c;
    @(negedge clk);
    start = 1'b0;
    took = 0;
    for (int j = 1; j <= 64; j++) begin
      if (poke && j == 1) begin
        start = 1'b1; operand = ~d; carry_in = ~c; cnt_reg = 8'd3; op = o + 3'd1;
      end
      @(negedge clk);
      if (poke && j == 1) start = 1'b0;
      if (done) begin took = j; break; end
    end
    check(n == 0 ? "R12 done timing" : "R2 done timing", took, n + 1);
    tg = poke ? "R3" : (n == 0 ? "R12" : op_tag(o));
    check({tg, " result"}, result, exp[15:0]);
    check(n > 1 ? "R13 carry" : {tg, " carry"}, carry_out, exp[16]);
    if (!wd) check("R11 upper byte", result[15:8], d[15:8]);
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hA5C3; pats[1] = 16'h8001; pats[2] = 16'h7E18; pats[3] = 16'h3C96;
    repeat (3) @(negedge clk);
    check("R1 result", result, 0);
    check("R1 carry", carry_out, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy, done, carry_out, result}, 0);
    for (int oi = 0; oi < 8; oi++)
      for (int wi = 0; wi < 2; wi++)
        for (int ci = 0; ci < 2; ci++)
          for (int pi = 0; pi < 4; pi++) begin
            run_one(3'(oi), bit'(wi), pats[pi], bit'(ci), 1'b0, 0, 1'b0);
            for (int k = 0; k <= 18; k++)
              run_one(3'(oi), bit'(wi), pats[pi], bit'(ci), 1'b1, k,
                      (pi == 1) && (k >= 2));
          end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule